// File: doc/BRIEF.md
# Programmable Periodic Tick Interrupt Generator

This block divides a slow reference tick into a periodic interrupt. A free-running 15-bit prescaler advances once per reference tick, a single-cycle enable pulse in the system clock domain. When the low bits picked by a 3-bit rate code wrap to zero, a pending flag is set. The divider table is fixed and non-uniform, from 32768 down to 8 ticks per event. With a 32.768 kHz reference this gives event rates of 1, 4, 16, 256, 512, 1024, 2048 and 4096 Hz.

Software uses the block through one 8-bit control/status register on a simple peripheral bus: address, write strobe, write data and combinational read data. The pending flag can be cleared only by writing one to a write-only acknowledge bit. The level interrupt request is the pending flag gated by an interrupt enable. The low-power indication does not stop the prescaler, so the block can serve as a wake-up source. Only clearing the run enable stops it.

Top module: `tbase_gen`

## Requirements
- R1: The register sits at address `REG_ADDR` (default 4'hC). Bit 7 is the pending flag and is read-only. Bits 6:4 are the rate code (read/write). Bit 3 is the acknowledge bit and always reads 0. Bit 2 is the interrupt enable and bit 1 the run enable, both read/write. Bit 0 always reads 0.
- R2: After reset every register bit reads 0 and `irq` is 0.
- R3: The rate code sets the number of reference ticks per event: 0→32768, 1→8192, 2→2048, 3→128, 4→64, 5→32, 6→16, 7→8.
- R4: With the run enable set and the counter starting at zero, the pending flag sets at the clock edge that samples the N-th tick, where N is the divider. It sets again every N ticks after that.
- R5: A register write with bit 3 = 1 clears the pending flag at that edge. A write with bit 3 = 0 leaves the flag unchanged.
- R6: `irq` is 1 exactly when both the pending flag and the interrupt enable are 1.
- R7: While the run enable is 0, the prescaler is held at zero and ticks are ignored. The first event after the run enable is set comes N ticks later.
- R8: Asserting `stop_mode` does not pause the prescaler (default `RUN_IN_STOP` = 1).
- R9: If a rollover and an acknowledge write occur in the same cycle, the pending flag ends set.
- R10: Writes to any other address change nothing. Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference tick pulse |
| stop_mode | input | 1 | Low-power indication from the system |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect at the clock edge that samples the strobe, and read data follows the address in the same cycle. The bench therefore reads back half a cycle after it drives the address. The pending flag and `irq` change at the edge that samples the N-th tick: one register stage after the tick, with the interrupt gating added combinationally. Every tick is driven and released on falling edges, and each check samples on a falling edge after the edge of interest. The check one tick before each expected event confirms that the flag does not set early.

// File: rtl/tbase_pkg.sv
// Package: shared register layout, control type and rate decode for the
// periodic tick interrupt generator. Assumes an 8-bit register.
package tbase_pkg;

    localparam int DATA_W   = 8;
    localparam int RATE_W   = 3;
    localparam int BIT_PEND = 7;
    localparam int RATE_LSB = 4;
    localparam int BIT_ACK  = 3;
    localparam int BIT_IE   = 2;
    localparam int BIT_RUN  = 1;

    // Control fields held by the register block.
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              ie;
        logic              run;
    } ctrl_t;

    // Rate code to log2 of the divider (ticks per event).
    function automatic int unsigned rate_shift(input logic [RATE_W-1:0] code);
        case (code)
            3'd0:    return 15;
            3'd1:    return 13;
            3'd2:    return 11;
            3'd3:    return 7;
            3'd4:    return 6;
            3'd5:    return 5;
            3'd6:    return 4;
            default: return 3;
        endcase
    endfunction

    // Largest shift in the table; sizes the prescaler.
    function automatic int unsigned max_shift();
        int unsigned m = 0;
        for (int i = 0; i < (1 << RATE_W); i++) begin
            if (rate_shift(RATE_W'(i)) > m) m = rate_shift(RATE_W'(i));
        end
        return m;
    endfunction

endpackage

// File: rtl/tbase_regs.sv
// Register block: decodes the single control/status register, holds the
// rate, interrupt enable and run enable, and produces the acknowledge pulse.
// Assumes one register at REG_ADDR; all other addresses read as zero.
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              pend,
    output ctrl_t             ctrl,
    output logic              ack_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    logic sel;
    logic wr_hit;
    logic unused_wr_bits;

    // Address match for the one register.
    assign sel    = (bus_addr == REG_ADDR);
    assign wr_hit = sel && bus_wr;

    // Acknowledge pulse: a write with the acknowledge bit set.
    assign ack_wr = wr_hit && bus_wdata[BIT_ACK];

    // The flag and reserved positions carry no write meaning.
    assign unused_wr_bits = ^{bus_wdata[BIT_PEND], bus_wdata[0]};

    // Capture the writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_hit) begin
            ctrl.rate <= bus_wdata[RATE_LSB +: RATE_W];
            ctrl.ie   <= bus_wdata[BIT_IE];
            ctrl.run  <= bus_wdata[BIT_RUN];
        end
    end

    // Read mux: acknowledge and reserved positions always return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel) begin
            bus_rdata[BIT_PEND]              = pend;
            bus_rdata[RATE_LSB +: RATE_W]    = ctrl.rate;
            bus_rdata[BIT_IE]                = ctrl.ie;
            bus_rdata[BIT_RUN]               = ctrl.run;
        end
    end

endmodule

// File: rtl/tbase_prescaler.sv
// Prescaler: counts reference ticks while running and flags a rollover when
// the low bits picked by the rate code wrap to zero. Held at zero while the
// run enable is low. RUN_IN_STOP picks whether the low-power indication
// pauses counting (0) or is ignored (1). Assumes ticks are one cycle wide.
module tbase_prescaler
    import tbase_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter bit RUN_IN_STOP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              stop,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  cnt,
    output logic              roll
);

    logic             adv;
    logic [CNT_W-1:0] mask;

    // Variant choice: the low-power indication either gates ticks or not.
    generate
        if (RUN_IN_STOP) begin : g_run_in_stop
            logic unused_stop;
            assign unused_stop = stop;
            assign adv = tick && run;
        end else begin : g_pause_in_stop
            assign adv = tick && run && !stop;
        end
    endgenerate

    // Mask of the counter bits that make up one period.
    assign mask = {CNT_W{1'b1}} >> (CNT_W - int'(rate_shift(rate)));

    // Rollover: this tick wraps the selected low bits to zero.
    assign roll = adv && ((cnt & mask) == mask);

    // Counter: cleared when stopped, advanced on each accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tbase_flag.sv
// Pending flag: set by a rollover and cleared by an acknowledge write. A
// rollover in the same cycle as an acknowledge wins, so no event is lost.
module tbase_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic roll,
    input  logic ack_wr,
    output logic pend
);

    // Flag update with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (roll) begin
            pend <= 1'b1;
        end else if (ack_wr) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/tbase_gen.sv
// Top: periodic tick interrupt generator. Ties the register block, the
// prescaler and the pending flag together and gates the interrupt request.
// Assumes ref_tick is synchronous to clk and one cycle wide.
module tbase_gen
    import tbase_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 'hC,
    parameter bit                RUN_IN_STOP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              stop_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);

    localparam int CNT_W = int'(max_shift());

    ctrl_t            ctrl_q;
    logic             ack_wr;
    logic             pend_q;
    logic             roll;
    logic [CNT_W-1:0] cnt_q;

    tbase_regs #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend      (pend_q),
        .ctrl      (ctrl_q),
        .ack_wr    (ack_wr),
        .bus_rdata (bus_rdata)
    );

    tbase_prescaler #(
        .CNT_W       (CNT_W),
        .RUN_IN_STOP (RUN_IN_STOP)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .run   (ctrl_q.run),
        .stop  (stop_mode),
        .rate  (ctrl_q.rate),
        .cnt   (cnt_q),
        .roll  (roll)
    );

    tbase_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .roll   (roll),
        .ack_wr (ack_wr),
        .pend   (pend_q)
    );

    // Level request: pending event gated by the interrupt enable.
    assign irq = pend_q && ctrl_q.ie;

endmodule

// File: rtl/tbase_chk.sv
// Checker: temporal properties of the tick interrupt generator, bound to
// the top so the design files stay free of verification code.
module tbase_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pend,
    input logic             run,
    input logic             ie,
    input logic             roll,
    input logic             ack_wr,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       rdata
);

    AST_ROLL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> pend);                                                  // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !roll) |=> !pend);                                    // R5

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!roll && !ack_wr) |=> $stable(pend));                           // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));                                           // R7

    AST_IDLE_NO_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !roll);                                                 // R7

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && ie));                                           // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[3] == 1'b0) && (rdata[0] == 1'b0));                       // R1

endmodule

bind tbase_gen tbase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (pend_q),
    .run    (ctrl_q.run),
    .ie     (ctrl_q.ie),
    .roll   (roll),
    .ack_wr (ack_wr),
    .irq    (irq),
    .cnt    (cnt_q),
    .rdata  (bus_rdata)
);

// File: tb/test_tbase_gen.sv
// Directed bench for the periodic tick interrupt generator.
module test_tbase_gen;

    localparam logic [3:0] RA = 4'hC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       stop_mode = 1'b0;
    logic [3:0] bus_addr = RA;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    tbase_gen i_tbase_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .stop_mode (stop_mode),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Expected divider for each rate code.
    function automatic int div_of(input int code);
        case (code)
            0: return 32768;  1: return 8192;  2: return 2048;  3: return 128;
            4: return 64;     5: return 32;    6: return 16;    default: return 8;
        endcase
    endfunction

    function automatic logic [7:0] mk(input int rate, input bit ack, input bit ie, input bit run);
        return {1'b0, 3'(rate), ack, ie, run, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = RA;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = RA;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic pend_is(input bit exp, input string req);
        logic [7:0] d;
        rd(RA, d);
        check(d[7] == exp, req, d[7], exp);
    endtask

    // R2: reset values.
    task automatic t_reset();
        logic [7:0] d;
        rd(RA, d);
        check(d == 8'h00, "R2 reg", d, 0);
        check(irq == 1'b0, "R2 irq", irq, 0);
    endtask

    // R1: layout, acknowledge and reserved bits read zero.
    task automatic t_layout();
        logic [7:0] d;
        wr(RA, 8'hFD);              // every bit but run set
        rd(RA, d);
        check(d == 8'h74, "R1 readback", d, 8'h74);
        wr(RA, 8'h00);
        rd(RA, d);
        check(d == 8'h00, "R1 cleared", d, 0);
    endtask

    // R3 R4 R6: each rate code, event exactly on the N-th tick.
    task automatic t_rates();
        for (int c = 0; c < 8; c++) begin
            int n = div_of(c);
            logic [7:0] d;
            wr(RA, mk(c, 0, 1, 0));
            wr(RA, mk(c, 0, 1, 1));
            ticks(n - 1);
            pend_is(1'b0, "R3 early");
            ticks(1);
            rd(RA, d);
            check(d == {1'b1, 3'(c), 4'b0110}, "R3 event", d, {1'b1, 3'(c), 4'b0110});
            check(irq == 1'b1, "R6 irq on", irq, 1);
            wr(RA, mk(c, 1, 1, 0));
            pend_is(1'b0, "R5 ack");
        end
    endtask

    // R4: repeats every N ticks without restart; R5: ack write of 0 no effect.
    task automatic t_periodic();
        wr(RA, mk(6, 0, 1, 1));
        ticks(16);
        pend_is(1'b1, "R4 first");
        wr(RA, mk(6, 0, 1, 1));
        pend_is(1'b1, "R5 zero ack");
        wr(RA, mk(6, 1, 1, 1));
        ticks(15);
        pend_is(1'b0, "R4 second early");
        ticks(1);
        pend_is(1'b1, "R4 second");
        wr(RA, mk(6, 1, 1, 0));
    endtask

    // R6: interrupt enable gates the request.
    task automatic t_gate();
        wr(RA, mk(7, 0, 0, 1));
        ticks(8);
        pend_is(1'b1, "R6 flag");
        check(irq == 1'b0, "R6 masked", irq, 0);
        wr(RA, mk(7, 0, 1, 1));
        check(irq == 1'b1, "R6 unmasked", irq, 1);
        wr(RA, mk(7, 1, 1, 0));
        check(irq == 1'b0, "R6 after ack", irq, 0);
    endtask

    // R7: stopped counter holds at zero and ignores ticks.
    task automatic t_hold();
        wr(RA, mk(7, 0, 1, 1));
        ticks(5);
        wr(RA, mk(7, 0, 1, 0));
        ticks(20);
        pend_is(1'b0, "R7 idle ticks");
        wr(RA, mk(7, 0, 1, 1));
        ticks(7);
        pend_is(1'b0, "R7 restart early");
        ticks(1);
        pend_is(1'b1, "R7 restart event");
        wr(RA, mk(7, 1, 1, 0));
    endtask

    // R8: low-power indication does not pause counting.
    task automatic t_stop();
        stop_mode = 1'b1;
        wr(RA, mk(7, 0, 1, 1));
        ticks(8);
        pend_is(1'b1, "R8 in stop");
        check(irq == 1'b1, "R8 irq", irq, 1);
        stop_mode = 1'b0;
        wr(RA, mk(7, 1, 1, 0));
    endtask

    // R9: rollover and acknowledge in the same cycle keep the flag set.
    task automatic t_race();
        wr(RA, mk(7, 0, 1, 1));
        ticks(8);
        ticks(7);
        @(negedge clk);
        ref_tick = 1'b1; bus_wr = 1'b1; bus_wdata = mk(7, 1, 1, 1);
        @(negedge clk);
        ref_tick = 1'b0; bus_wr = 1'b0;
        pend_is(1'b1, "R9 race");
        wr(RA, mk(7, 1, 1, 0));
        pend_is(1'b0, "R9 later ack");
    endtask

    // R10: other addresses neither write nor read back.
    task automatic t_decode();
        logic [7:0] d;
        wr(4'h3, 8'h76);
        rd(RA, d);
        check(d == 8'h00, "R10 foreign write", d, 0);
        wr(RA, mk(2, 0, 1, 0));
        rd(4'h5, d);
        check(d == 8'h00, "R10 foreign read", d, 0);
        wr(RA, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_decode();
        t_periodic();
        t_gate();
        t_hold();
        t_stop();
        t_race();
        t_rates();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule